// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block drives the row and column strobes of an asynchronous DRAM whenever the memory must be kept alive rather than accessed. After reset it holds every strobe inactive for a programmable power-up delay. It then runs a fixed number of warm-up refresh cycles and only after those raises a ready flag. From that point a free-running interval timer schedules refreshes in which the column strobe leads the row strobe. Each refresh asks the access controller for the bus and starts only once the bus is granted.

If the grant is held back, missed refresh slots are counted up to a parameterised limit. They are then issued back to back as soon as the grant arrives. A low-power request/acknowledge pair puts the memory into self-refresh by holding both strobes low for at least a minimum time. Exit adds an extended precharge, and periodic refresh then resumes. Write-enable and output-enable stay inactive throughout, and the block never drives the data bus. All delays are counted in clock cycles.

Top module: `dram_refresh_seq`

## Requirements
- R1: While rst_ni is low, ready_o, bus_req_o and sleep_ack_o are 0, and ras_no, cas_lo_no and cas_hi_no are 1.
- R2: For the first PWRUP_CYC cycles after reset release, bus_req_o stays 0 and the row strobe does not fall.
- R3: After the power-up delay, exactly INIT_REFS refresh cycles run back to back. ready_o then rises and never falls again until reset.
- R4: In every refresh, both column strobes (low = active) are low for at least CSR_CYC cycles before ras_no falls. They stay low for at least CHR_CYC cycles after it falls, and the two column strobes always carry the same value.
- R5: In a normal refresh, ras_no is low for exactly RAS_LOW_CYC cycles. It is high for at least RP_CYC cycles before the next fall.
- R6: With bus_grant_i held high after ready, consecutive refreshes start exactly INTERVAL_CYC cycles apart.
- R7: A refresh starts only after bus_grant_i is seen high. bus_req_o is high whenever ras_no is low, and it is raised while a refresh is due but not granted.
- R8: Refresh slots that fall due without a grant are accumulated up to MAX_PEND; any beyond that are dropped. The accumulated refreshes then run back to back, each starting CSR_CYC+RAS_LOW_CYC+RP_CYC cycles after the previous one.
- R9: we_no and oe_no are always 1, and dq_oe_o (data bus drive enable) is always 0.
- R10: Raising sleep_req_i after ready starts a self-refresh. The column strobes fall before the row strobe, and sleep_ack_o is 1 only while both strobes are held low. The row strobe stays low for at least SELF_MIN_CYC cycles, even if the request drops earlier.
- R11: After sleep_req_i drops and the minimum has elapsed, sleep_ack_o falls. The row strobe stays high for at least SELF_RP_CYC cycles, and the next periodic refresh starts within INTERVAL_CYC+SELF_RP_CYC+15 cycles of the acknowledge falling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_grant_i | input | 1 | Access controller grants the DRAM strobes to this block |
| sleep_req_i | input | 1 | Request to enter and remain in self-refresh |
| bus_req_o | output | 1 | Requests the DRAM strobes |
| sleep_ack_o | output | 1 | Self-refresh is active |
| ready_o | output | 1 | Initialisation complete |
| ras_no | output | 1 | Row address strobe, active low |
| cas_lo_no | output | 1 | Lower byte column strobe, active low |
| cas_hi_no | output | 1 | Upper byte column strobe, active low |
| we_no | output | 1 | Write enable, active low, held inactive |
| oe_no | output | 1 | Output enable, active low, held inactive |
| dq_oe_o | output | 1 | Data bus drive enable, held off |

## Verification
A due refresh reaches the pins three clock edges after its interval tick. The first edge raises the pending count, the second raises the request, and the third, with grant already high, drops the column strobes; the row strobe falls one column-setup period later. The bench therefore checks the row strobe's spacing from fall to fall and never against an absolute time. Strobe order, pulse widths and precharge widths are measured by a monitor that samples on the falling clock edge and keeps run lengths of each strobe level. Scenario tasks advance on that same falling edge plus a small delay, so every value they read has already settled for the cycle.

// File: rtl/drs_pkg.sv
package drs_pkg;

  typedef enum logic [3:0] {
    ST_PWRUP,
    ST_IDLE,
    ST_REQ,
    ST_CAS_SET,
    ST_RAS_LOW,
    ST_PRECH,
    ST_SR_SET,
    ST_SR_LOW,
    ST_SR_EXIT
  } seq_state_e;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/drs_interval.sv
module drs_interval #(
  parameter int INTERVAL_CYC = 60,
  parameter int MAX_PEND     = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic take_i,
  output logic has_pend_o
);

  localparam int TW = $clog2(INTERVAL_CYC);
  localparam int PW = $clog2(MAX_PEND + 1);

  logic [TW-1:0] tcnt_q;
  logic [PW-1:0] pend_q;
  logic          tick;
  logic          inc, dec;

  assign tick = en_i && (tcnt_q == TW'(INTERVAL_CYC - 1));
  assign inc  = tick && (pend_q != PW'(MAX_PEND));
  assign dec  = take_i && (pend_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tcnt_q <= '0;
      pend_q <= '0;
    end else if (!en_i) begin
      tcnt_q <= '0;
      pend_q <= '0;
    end else begin
      tcnt_q <= tick ? '0 : tcnt_q + TW'(1);
      case ({inc, dec})
        2'b10:   pend_q <= pend_q + PW'(1);
        2'b01:   pend_q <= pend_q - PW'(1);
        default: pend_q <= pend_q;
      endcase
    end
  end

  assign has_pend_o = (pend_q != '0);

  assert_pend_cap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q <= PW'(MAX_PEND));

  assert_pend_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(en_i) && en_i && !$stable(pend_q)) |->
      (pend_q == $past(pend_q) + PW'(1) || pend_q + PW'(1) == $past(pend_q)));

endmodule

// File: rtl/drs_seq_fsm.sv
module drs_seq_fsm
  import drs_pkg::*;
#(
  parameter int PWRUP_CYC    = 20,
  parameter int INIT_REFS    = 8,
  parameter int CSR_CYC      = 1,
  parameter int CHR_CYC      = 2,
  parameter int RAS_LOW_CYC  = 4,
  parameter int RP_CYC       = 3,
  parameter int SELF_MIN_CYC = 30,
  parameter int SELF_RP_CYC  = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bus_grant_i,
  input  logic sleep_req_i,
  input  logic has_pend_i,
  output logic take_o,
  output logic timer_en_o,
  output logic bus_req_o,
  output logic sleep_ack_o,
  output logic ready_o,
  output logic ras_no,
  output logic cas_no
);

  localparam int MAXD = max_of(max_of(max_of(PWRUP_CYC, SELF_MIN_CYC), max_of(RAS_LOW_CYC, RP_CYC)),
                               max_of(CSR_CYC, SELF_RP_CYC));
  localparam int CW   = $clog2(MAXD + 1);
  localparam int IW   = $clog2(INIT_REFS + 1);

  seq_state_e    st_q, st_d;
  logic [CW-1:0] cnt_q;
  logic [IW-1:0] init_q;
  logic          ready_q;
  logic          pwrup_done, csr_done, ras_done, rp_done, srmin_done, srrp_done;
  logic          init_last, more, take, sleeping;

  assign pwrup_done = (cnt_q == CW'(PWRUP_CYC - 1));
  assign csr_done   = (cnt_q == CW'(CSR_CYC - 1));
  assign ras_done   = (cnt_q == CW'(RAS_LOW_CYC - 1));
  assign rp_done    = (cnt_q == CW'(RP_CYC - 1));
  assign srmin_done = (cnt_q == CW'(SELF_MIN_CYC - 1));
  assign srrp_done  = (cnt_q == CW'(SELF_RP_CYC - 1));
  assign init_last  = (init_q == IW'(INIT_REFS - 1));
  // another refresh follows the current one without releasing the bus
  assign more       = ready_q ? has_pend_i : !init_last;

  always_comb begin
    st_d = st_q;
    take = 1'b0;
    unique case (st_q)
      ST_PWRUP:   if (pwrup_done) st_d = ST_REQ;
      ST_IDLE:    if (has_pend_i || sleep_req_i) st_d = ST_REQ;
      ST_REQ: begin
        if (!ready_q || has_pend_i) begin
          if (bus_grant_i) begin
            st_d = ST_CAS_SET;
            take = ready_q;
          end
        end else if (sleep_req_i) begin
          if (bus_grant_i) st_d = ST_SR_SET;
        end else begin
          st_d = ST_IDLE;
        end
      end
      ST_CAS_SET: if (csr_done) st_d = ST_RAS_LOW;
      ST_RAS_LOW: if (ras_done) st_d = ST_PRECH;
      ST_PRECH: begin
        if (rp_done) begin
          if (more) begin
            st_d = ST_CAS_SET;
            take = ready_q;
          end else begin
            st_d = ST_IDLE;
          end
        end
      end
      ST_SR_SET:  if (csr_done) st_d = ST_SR_LOW;
      ST_SR_LOW:  if (srmin_done && !sleep_req_i) st_d = ST_SR_EXIT;
      ST_SR_EXIT: if (srrp_done) st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_PWRUP;
      cnt_q   <= '0;
      init_q  <= '0;
      ready_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_d != st_q || st_q == ST_PRECH && rp_done) cnt_q <= '0;
      else if (st_q == ST_IDLE || st_q == ST_REQ) cnt_q <= '0;
      else if (!(st_q == ST_SR_LOW && srmin_done)) cnt_q <= cnt_q + CW'(1);
      if (st_q == ST_PRECH && rp_done && !ready_q) begin
        if (init_last) ready_q <= 1'b1;
        else init_q <= init_q + IW'(1);
      end
    end
  end

  assign sleeping    = (st_q == ST_SR_SET) || (st_q == ST_SR_LOW) || (st_q == ST_SR_EXIT);
  assign take_o      = take;
  assign timer_en_o  = ready_q && !sleeping;
  assign bus_req_o   = (st_q != ST_PWRUP) && (st_q != ST_IDLE);
  assign sleep_ack_o = (st_q == ST_SR_LOW);
  assign ready_o     = ready_q;
  assign ras_no      = !((st_q == ST_RAS_LOW) || (st_q == ST_SR_LOW));
  assign cas_no      = !((st_q == ST_CAS_SET) || (st_q == ST_SR_SET) || (st_q == ST_SR_LOW) ||
                         (st_q == ST_RAS_LOW && cnt_q < CW'(CHR_CYC)));

  assert_cas_lead_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_no) |-> (!cas_no && $past(!cas_no)));

  assert_ready_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_q |=> ready_q);

  assert_ready_after_init_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_q) |-> $past(st_q == ST_PRECH));

  assert_ras_needs_bus_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ras_no |-> bus_req_o);

  assert_ack_strobes_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_ack_o |-> (!ras_no && !cas_no));

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq #(
  parameter int PWRUP_CYC    = 20000,
  parameter int INIT_REFS    = 8,
  parameter int INTERVAL_CYC = 1560,
  parameter int MAX_PEND     = 8,
  parameter int CSR_CYC      = 1,
  parameter int CHR_CYC      = 2,
  parameter int RAS_LOW_CYC  = 6,
  parameter int RP_CYC       = 4,
  parameter int SELF_MIN_CYC = 10000,
  parameter int SELF_RP_CYC  = 11
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bus_grant_i,
  input  logic sleep_req_i,
  output logic bus_req_o,
  output logic sleep_ack_o,
  output logic ready_o,
  output logic ras_no,
  output logic cas_lo_no,
  output logic cas_hi_no,
  output logic we_no,
  output logic oe_no,
  output logic dq_oe_o
);

  logic has_pend, take, timer_en, cas_n;

  drs_interval #(
    .INTERVAL_CYC(INTERVAL_CYC),
    .MAX_PEND    (MAX_PEND)
  ) u_interval (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (timer_en),
    .take_i    (take),
    .has_pend_o(has_pend)
  );

  drs_seq_fsm #(
    .PWRUP_CYC   (PWRUP_CYC),
    .INIT_REFS   (INIT_REFS),
    .CSR_CYC     (CSR_CYC),
    .CHR_CYC     (CHR_CYC),
    .RAS_LOW_CYC (RAS_LOW_CYC),
    .RP_CYC      (RP_CYC),
    .SELF_MIN_CYC(SELF_MIN_CYC),
    .SELF_RP_CYC (SELF_RP_CYC)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bus_grant_i(bus_grant_i),
    .sleep_req_i(sleep_req_i),
    .has_pend_i (has_pend),
    .take_o     (take),
    .timer_en_o (timer_en),
    .bus_req_o  (bus_req_o),
    .sleep_ack_o(sleep_ack_o),
    .ready_o    (ready_o),
    .ras_no     (ras_no),
    .cas_no     (cas_n)
  );

  // both byte strobes low together: the part reads this as refresh, not access
  assign cas_lo_no = cas_n;
  assign cas_hi_no = cas_n;
  assign we_no     = 1'b1;
  assign oe_no     = 1'b1;
  assign dq_oe_o   = 1'b0;

endmodule

// File: tb/dram_refresh_seq_test.sv
module dram_refresh_seq_test;

  localparam int CLK_PERIOD   = 10;
  localparam int PWRUP_CYC    = 20;
  localparam int INIT_REFS    = 8;
  localparam int INTERVAL_CYC = 60;
  localparam int MAX_PEND     = 3;
  localparam int CSR_CYC      = 1;
  localparam int CHR_CYC      = 2;
  localparam int RAS_LOW_CYC  = 4;
  localparam int RP_CYC       = 3;
  localparam int SELF_MIN_CYC = 30;
  localparam int SELF_RP_CYC  = 5;
  localparam int BURST_GAP    = CSR_CYC + RAS_LOW_CYC + RP_CYC;
  localparam int WD_CYC       = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic grant = 1'b1;
  logic sleep_req = 1'b0;
  logic bus_req, sleep_ack, ready, ras_n, cas_lo_n, cas_hi_n, we_n, oe_n, dq_oe;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dram_refresh_seq #(
    .PWRUP_CYC(PWRUP_CYC), .INIT_REFS(INIT_REFS), .INTERVAL_CYC(INTERVAL_CYC),
    .MAX_PEND(MAX_PEND), .CSR_CYC(CSR_CYC), .CHR_CYC(CHR_CYC), .RAS_LOW_CYC(RAS_LOW_CYC),
    .RP_CYC(RP_CYC), .SELF_MIN_CYC(SELF_MIN_CYC), .SELF_RP_CYC(SELF_RP_CYC)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_grant_i(grant), .sleep_req_i(sleep_req),
    .bus_req_o(bus_req), .sleep_ack_o(sleep_ack), .ready_o(ready), .ras_no(ras_n),
    .cas_lo_no(cas_lo_n), .cas_hi_no(cas_hi_n), .we_no(we_n), .oe_no(oe_n), .dq_oe_o(dq_oe)
  );

  // strobe monitor, sampled on the falling edge
  int  cyc = 0, falls = 0, first_fall = -1, last_fall = 0, gap = 0;
  int  cas_low_run = 0, ras_low_run = 0, ras_high_run = 0, cas_hold = 0, last_sr_low = 0;
  int  v_r4 = 0, v_r5 = 0, v_r7 = 0, v_r9 = 0, v_r11 = 0;
  bit  prev_ras = 1'b1, prev_cas = 1'b1, sr_prev = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (!we_n || !oe_n || dq_oe) v_r9++;
      if (cas_lo_n != cas_hi_n) v_r4++;
      if (!ras_n && !bus_req) v_r7++;
      if (prev_cas && !cas_lo_n && !grant) v_r7++;
      if (prev_ras && !ras_n) begin
        if (cas_low_run < CSR_CYC || cas_lo_n) v_r4++;
        if (sr_prev && ras_high_run < SELF_RP_CYC) v_r11++;
        if (!sr_prev && ras_high_run < RP_CYC) v_r5++;
        gap = cyc - last_fall;
        last_fall = cyc;
        if (first_fall < 0) first_fall = cyc;
        falls++;
      end
      if (!prev_ras && ras_n) begin
        if (ras_low_run > RAS_LOW_CYC) begin
          sr_prev = 1'b1;
          last_sr_low = ras_low_run;
        end else begin
          sr_prev = 1'b0;
          if (ras_low_run != RAS_LOW_CYC) v_r5++;
        end
      end
      if (!prev_cas && cas_lo_n && !ras_n && cas_hold < CHR_CYC) v_r4++;
      cas_low_run  = cas_lo_n ? 0 : cas_low_run + 1;
      ras_low_run  = ras_n ? 0 : ras_low_run + 1;
      ras_high_run = ras_n ? ras_high_run + 1 : 0;
      cas_hold     = (!ras_n && !cas_lo_n) ? cas_hold + 1 : 0;
      prev_ras     = ras_n;
      prev_cas     = cas_lo_n;
    end
  end

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic wait_fall(input int limit, output bit ok);
    int f;
    f  = falls;
    ok = 1'b0;
    for (int i = 0; i < limit && !ok; i++) begin
      step(1);
      if (falls != f) ok = 1'b1;
    end
  endtask

  task automatic test_reset();
    step(3);
    chk("R1 ready", ready == 1'b0, ready, 0);
    chk("R1 bus_req", bus_req == 1'b0, bus_req, 0);
    chk("R1 sleep_ack", sleep_ack == 1'b0, sleep_ack, 0);
    chk("R1 strobes", ras_n && cas_lo_n && cas_hi_n, {ras_n, cas_lo_n, cas_hi_n}, 7);
    @(negedge clk);
    rst_n = 1'b1;
    step(PWRUP_CYC - 1);
    chk("R2 no request in power-up", bus_req == 1'b0, bus_req, 0);
    chk("R2 no ras fall in power-up", falls == 0, falls, 0);
  endtask

  task automatic test_init();
    int n = 0;
    while (!ready && n < 2000) begin
      step(1);
      n++;
    end
    chk("R3 ready rises", ready == 1'b1, ready, 1);
    chk("R3 warm-up count", falls == INIT_REFS, falls, INIT_REFS);
    chk("R2 first fall after delay", first_fall >= PWRUP_CYC, first_fall, PWRUP_CYC);
    chk("R3 warm-up back to back", gap == BURST_GAP, gap, BURST_GAP);
    step(20);
    chk("R3 ready held", ready == 1'b1, ready, 1);
  endtask

  task automatic test_periodic();
    bit ok;
    wait_fall(INTERVAL_CYC + 20, ok);
    chk("R6 first periodic refresh", ok, ok, 1);
    for (int k = 0; k < 3; k++) begin
      wait_fall(INTERVAL_CYC + 20, ok);
      chk("R6 refresh spacing", ok && gap == INTERVAL_CYC, gap, INTERVAL_CYC);
    end
  endtask

  task automatic test_backlog();
    bit ok;
    int f;
    wait_fall(INTERVAL_CYC + 20, ok);
    step(10);
    grant = 1'b0;
    f = falls;
    step(5 * INTERVAL_CYC);
    chk("R7 no refresh without grant", falls == f, falls - f, 0);
    chk("R7 request raised while due", bus_req == 1'b1, bus_req, 1);
    grant = 1'b1;
    step(35);
    chk("R8 saturated backlog count", falls - f == MAX_PEND, falls - f, MAX_PEND);
    chk("R8 backlog back to back", gap == BURST_GAP, gap, BURST_GAP);
  endtask

  task automatic test_sleep();
    bit ok;
    int n = 0;
    int ack_cyc;
    wait_fall(INTERVAL_CYC + 20, ok);
    step(20);
    sleep_req = 1'b1;
    while (!sleep_ack && n < 50) begin
      step(1);
      n++;
    end
    chk("R10 ack raised", sleep_ack == 1'b1, sleep_ack, 1);
    chk("R10 strobes low in self-refresh", !ras_n && !cas_lo_n && !cas_hi_n,
        {ras_n, cas_lo_n, cas_hi_n}, 0);
    step(5);
    sleep_req = 1'b0;
    step(10);
    chk("R10 held to minimum", sleep_ack == 1'b1 && !ras_n, sleep_ack, 1);
    n = 0;
    while (sleep_ack && n < 100) begin
      step(1);
      n++;
    end
    chk("R11 ack falls", sleep_ack == 1'b0, sleep_ack, 0);
    ack_cyc = cyc;
    wait_fall(INTERVAL_CYC + SELF_RP_CYC + 40, ok);
    chk("R10 self-refresh low width", last_sr_low >= SELF_MIN_CYC, last_sr_low, SELF_MIN_CYC);
    chk("R11 exit precharge", v_r11 == 0, v_r11, 0);
    chk("R11 refresh resumes", ok && (last_fall - ack_cyc) >= INTERVAL_CYC &&
        (last_fall - ack_cyc) <= INTERVAL_CYC + SELF_RP_CYC + 15, last_fall - ack_cyc, INTERVAL_CYC);
  endtask

  task automatic test_totals();
    chk("R4 strobe ordering", v_r4 == 0, v_r4, 0);
    chk("R5 ras width and precharge", v_r5 == 0, v_r5, 0);
    chk("R7 strobes only with bus", v_r7 == 0, v_r7, 0);
    chk("R9 we/oe/dq passive", v_r9 == 0, v_r9, 0);
  endtask

  initial begin
    test_reset();
    test_init();
    test_periodic();
    test_backlog();
    test_sleep();
    test_totals();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WD_CYC) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", WD_CYC, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule